// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the eight-bit status word of a small eight-bit controller core. Whenever the core's ALU finishes an operation, the block receives the operation class, both operands and the result. It works out the carry, nibble-carry, zero and signed-overflow flags from these and registers them. Each class of operation touches only the flags that belong to it. The other flags hold their values.

Two more flags follow system events. The sleep flag records that the core executed a halt. The watchdog-expiry flag records that the watchdog timer ran out. Both are cleared by power-up reset and by a watchdog-clear instruction. A halt also clears the watchdog-expiry flag. The whole word is available at all times on a read port, and every update appears there one clock after the event or operation that causes it.

Top module: `status_flag_reg`

## Requirements
- R1: While the active-low power-up reset `rst_n` is low, and on the first clock after it is released with no other activity, `status_o` reads 0x00.
- R2: Carry (bit 0). ADD (code 1) and ADC (code 2) compute a + b + cin, and carry is set when the sum exceeds 0xFF. SUB (code 3) and SBC (code 4) compute a + ~b + cin, so carry is set when no borrow occurs. cin is 0 for ADD, 1 for SUB, and the current carry bit for ADC and SBC.
- R3: Nibble carry (bit 1) is set on those same four operations when the low nibbles of a, b (or ~b) and cin together carry into bit 4. On subtraction this means no borrow from the high nibble.
- R4: Zero (bit 2) is set when `res_i` equals 0x00 on any arithmetic operation or on LOGIC (code 5), and is cleared otherwise.
- R5: Overflow (bit 3) is set on the four arithmetic operations when the carry into bit 7 differs from the carry out of bit 7. Two cases follow from this: 0x7F+0x01 and 0x80-0x01 both set it.
- R6: LOGIC changes only bit 2. ROL (code 6) loads carry from a[7], and ROR (code 7) loads it from a[0]. Neither rotate changes any other bit. Code 0, or `alu_valid_i` low, changes no flag.
- R7: Sleep (bit 4): `wdt_clr_i` clears it, otherwise `halt_i` sets it. If both are asserted in the same cycle, the clear wins.
- R8: Watchdog expiry (bit 5): `wdt_to_i` sets it, and this wins over any clear in the same cycle. Otherwise `wdt_clr_i` or `halt_i` clears it.
- R9: Bits 7 and 6 of `status_o` always read 0, and every flag change shows on `status_o` exactly one clock after the inputs that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| alu_valid_i | input | 1 | An ALU operation completes this cycle |
| alu_op_i | input | 3 | Operation class code (see R2 to R6) |
| opa_i | input | 8 | First operand a |
| opb_i | input | 8 | Second operand b |
| res_i | input | 8 | ALU result |
| wdt_clr_i | input | 1 | Watchdog-clear instruction strobe |
| halt_i | input | 1 | Halt instruction strobe |
| wdt_to_i | input | 1 | Watchdog time-out strobe |
| status_o | output | 8 | Status word read port |

## Verification
A wrong carry chain shows up on the very next cycle, as a wrong bit 0, 1 or 3. It then spreads through later ADC and SBC results, because the stored carry feeds their carry-in. A flag that is updated by the wrong operation class appears as a change on a bit that should have held its value. The per-cycle comparison catches that one clock after the offending operation. A priority error in the event logic shows only when strobes collide, so those collisions are driven on purpose and also occur at random.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int STAT_W = 8;

  localparam int C_POS  = 0;
  localparam int AC_POS = 1;
  localparam int Z_POS  = 2;
  localparam int OV_POS = 3;
  localparam int PD_POS = 4;
  localparam int TO_POS = 5;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_ADC   = 3'd2,
    OP_SUB   = 3'd3,
    OP_SBC   = 3'd4,
    OP_LOGIC = 3'd5,
    OP_ROL   = 3'd6,
    OP_ROR   = 3'd7
  } alu_op_e;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC);
  endfunction

  function automatic logic op_is_sub(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBC);
  endfunction

  function automatic logic op_is_rot(alu_op_e op);
    return (op == OP_ROL) || (op == OP_ROR);
  endfunction

  // carry-in chosen per class: plain add 0, plain subtract 1, chained forms use stored carry
  function automatic logic op_cin(alu_op_e op, logic c_now);
    logic r;
    case (op)
      OP_SUB:          r = 1'b1;
      OP_ADC, OP_SBC:  r = c_now;
      default:         r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sf_carry_chain.sv
module sf_carry_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W:0]   carry_o
);
  assign carry_o[0] = cin_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign carry_o[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & carry_o[i]) | (b_i[i] & carry_o[i]);
  end
endmodule

// File: rtl/sf_alu_flags.sv
module sf_alu_flags
  import sf_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int NIB = NIB_W
) (
  input  logic         valid_i,
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] res_i,
  input  logic         c_now_i,
  output logic         upd_c_o,
  output logic         upd_ac_o,
  output logic         upd_z_o,
  output logic         upd_ov_o,
  output logic         nxt_c_o,
  output logic         nxt_ac_o,
  output logic         nxt_z_o,
  output logic         nxt_ov_o,
  output logic         nib_carry_o,
  output logic         msb_cin_o,
  output logic         msb_cout_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   chain;
  logic         cin;

  assign b_eff = op_is_sub(op_i) ? ~b_i : b_i;
  assign cin   = op_cin(op_i, c_now_i);

  sf_carry_chain #(.W(W)) u_chain (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin),
    .carry_o(chain)
  );

  assign nib_carry_o = chain[NIB];
  assign msb_cin_o   = chain[W-1];
  assign msb_cout_o  = chain[W];

  always_comb begin
    upd_c_o  = valid_i & (op_is_arith(op_i) | op_is_rot(op_i));
    upd_ac_o = valid_i & op_is_arith(op_i);
    upd_ov_o = valid_i & op_is_arith(op_i);
    upd_z_o  = valid_i & (op_is_arith(op_i) | (op_i == OP_LOGIC));
    nxt_ac_o = nib_carry_o;
    nxt_ov_o = msb_cin_o ^ msb_cout_o;
    nxt_z_o  = (res_i == '0);
    case (op_i)
      OP_ROL:  nxt_c_o = a_i[W-1];
      OP_ROR:  nxt_c_o = a_i[0];
      default: nxt_c_o = msb_cout_o;
    endcase
  end
endmodule

// File: rtl/sf_pm_flags.sv
module sf_pm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_clr_i,
  input  logic halt_i,
  input  logic wdt_to_i,
  output logic pd_o,
  output logic to_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_o <= 1'b0;
      to_o <= 1'b0;
    end else begin
      if (wdt_clr_i)   pd_o <= 1'b0;
      else if (halt_i) pd_o <= 1'b1;
      if (wdt_to_i)                to_o <= 1'b1;
      else if (wdt_clr_i | halt_i) to_o <= 1'b0;
    end
  end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_valid_i,
  input  logic [2:0]        alu_op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              wdt_clr_i,
  input  logic              halt_i,
  input  logic              wdt_to_i,
  output logic [STAT_W-1:0] status_o
);
  localparam int ARITH_FLAGS = 4;

  alu_op_e op;
  logic    c_q, ac_q, z_q, ov_q, pd_q, to_q;
  logic    upd_c, upd_ac, upd_z, upd_ov;
  logic    nxt_c, nxt_ac, nxt_z, nxt_ov;
  logic    nib_carry, msb_cin, msb_cout;
  logic [ARITH_FLAGS-1:0] upd_vec, nxt_vec, cur_vec;

  assign op = alu_op_e'(alu_op_i);

  sf_alu_flags #(.W(DATA_W), .NIB(NIB_W)) u_alu_flags (
    .valid_i    (alu_valid_i),
    .op_i       (op),
    .a_i        (opa_i),
    .b_i        (opb_i),
    .res_i      (res_i),
    .c_now_i    (c_q),
    .upd_c_o    (upd_c),
    .upd_ac_o   (upd_ac),
    .upd_z_o    (upd_z),
    .upd_ov_o   (upd_ov),
    .nxt_c_o    (nxt_c),
    .nxt_ac_o   (nxt_ac),
    .nxt_z_o    (nxt_z),
    .nxt_ov_o   (nxt_ov),
    .nib_carry_o(nib_carry),
    .msb_cin_o  (msb_cin),
    .msb_cout_o (msb_cout)
  );

  assign upd_vec = {upd_ov, upd_z, upd_ac, upd_c};
  assign nxt_vec = {nxt_ov, nxt_z, nxt_ac, nxt_c};
  assign {ov_q, z_q, ac_q, c_q} = cur_vec;

  for (genvar k = 0; k < ARITH_FLAGS; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cur_vec[k] <= 1'b0;
      else if (upd_vec[k]) cur_vec[k] <= nxt_vec[k];
    end
  end

  sf_pm_flags u_pm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdt_clr_i(wdt_clr_i),
    .halt_i   (halt_i),
    .wdt_to_i (wdt_to_i),
    .pd_o     (pd_q),
    .to_o     (to_q)
  );

  always_comb begin
    status_o         = '0;
    status_o[C_POS]  = c_q;
    status_o[AC_POS] = ac_q;
    status_o[Z_POS]  = z_q;
    status_o[OV_POS] = ov_q;
    status_o[PD_POS] = pd_q;
    status_o[TO_POS] = to_q;
  end
endmodule

// File: rtl/sf_status_checker.sv
module sf_status_checker
  import sf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              alu_valid_i,
  input logic [2:0]        alu_op_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] res_i,
  input logic              wdt_clr_i,
  input logic              halt_i,
  input logic              wdt_to_i,
  input logic              msb_cin,
  input logic              msb_cout,
  input logic [STAT_W-1:0] status_o
);
  logic arith_now, quiet_now;
  assign arith_now = alu_valid_i && (alu_op_i >= 3'd1) && (alu_op_i <= 3'd4);
  assign quiet_now = !wdt_clr_i && !halt_i && !wdt_to_i && (!alu_valid_i || alu_op_i == 3'd0);

  always @(posedge clk) begin
    if (rst_n) assert_top_bits_zero_R9: assert (status_o[7:6] == 2'b00);
  end

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> (status_o == '0 || rst_n));

  assert_ov_from_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arith_now |=> status_o[OV_POS] == $past(msb_cin ^ msb_cout));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_now || (alu_valid_i && alu_op_i == 3'd5)) |=> status_o[Z_POS] == ($past(res_i) == '0));

  assert_logic_keeps_others_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid_i && alu_op_i == 3'd5) |=> $stable({status_o[OV_POS], status_o[AC_POS], status_o[C_POS]}));

  assert_rol_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid_i && alu_op_i == 3'd6) |=> status_o[C_POS] == $past(opa_i[DATA_W-1]));

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_now |=> $stable(status_o));

  assert_pd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr_i |=> !status_o[PD_POS]);

  assert_pd_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !wdt_clr_i) |=> status_o[PD_POS]);

  assert_to_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to_i |=> status_o[TO_POS]);

  assert_to_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wdt_clr_i || halt_i) && !wdt_to_i) |=> !status_o[TO_POS]);
endmodule

bind status_flag_reg sf_status_checker u_sf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alu_valid_i(alu_valid_i),
  .alu_op_i   (alu_op_i),
  .opa_i      (opa_i),
  .res_i      (res_i),
  .wdt_clr_i  (wdt_clr_i),
  .halt_i     (halt_i),
  .wdt_to_i   (wdt_to_i),
  .msb_cin    (msb_cin),
  .msb_cout   (msb_cout),
  .status_o   (status_o)
);

// File: tb/test_status_flag_reg.sv
module test_status_flag_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_valid_i = 1'b0;
  logic [2:0] alu_op_i = 3'd0;
  logic [7:0] opa_i = 8'd0, opb_i = 8'd0, res_i = 8'd0;
  logic       wdt_clr_i = 1'b0, halt_i = 1'b0, wdt_to_i = 1'b0;
  logic [7:0] status_o;

  int n_cmp = 0, n_bad = 0;
  int m_c = 0, m_ac = 0, m_z = 0, m_ov = 0, m_pd = 0, m_to = 0;
  bit done = 0;

  always #2 clk = ~clk;

  status_flag_reg i_status_flag_reg (
    .clk(clk), .rst_n(rst_n), .alu_valid_i(alu_valid_i), .alu_op_i(alu_op_i),
    .opa_i(opa_i), .opb_i(opb_i), .res_i(res_i), .wdt_clr_i(wdt_clr_i),
    .halt_i(halt_i), .wdt_to_i(wdt_to_i), .status_o(status_o)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 carry",       status_o[0], m_c);
    chk("R3 nibble",      status_o[1], m_ac);
    chk("R4 zero",        status_o[2], m_z);
    chk("R5 overflow",    status_o[3], m_ov);
    chk("R7 sleep",       status_o[4], m_pd);
    chk("R8 expiry",      status_o[5], m_to);
    chk("R9 upper zero",  status_o[7:6], 0);
  endtask

  // behavioural reference: integer sums, no bit chain
  task automatic model_step();
    int a, b, ci, s, lo;
    a = opa_i; b = opb_i;
    if (alu_valid_i) begin
      if (alu_op_i >= 1 && alu_op_i <= 4) begin
        if (alu_op_i >= 3) b = 255 - b;
        ci = (alu_op_i == 1) ? 0 : (alu_op_i == 3) ? 1 : m_c;
        s  = a + b + ci;
        lo = (a % 16) + (b % 16) + ci;
        m_c  = (s > 255) ? 1 : 0;
        m_ac = (lo > 15) ? 1 : 0;
        m_ov = ((a >= 128) == (b >= 128) && ((s % 256) >= 128) != (a >= 128)) ? 1 : 0;
        m_z  = (res_i == 0) ? 1 : 0;
      end else if (alu_op_i == 5) m_z = (res_i == 0) ? 1 : 0;
      else if (alu_op_i == 6) m_c = a / 128;
      else if (alu_op_i == 7) m_c = a % 2;
    end
    if (wdt_clr_i) m_pd = 0; else if (halt_i) m_pd = 1;
    if (wdt_to_i) m_to = 1; else if (wdt_clr_i || halt_i) m_to = 0;
  endtask

  function automatic logic [7:0] arith_res(int op, int a, int b, int c);
    int bb, ci;
    bb = (op >= 3) ? 255 - b : b;
    ci = (op == 1) ? 0 : (op == 3) ? 1 : c;
    return 8'((a + bb + ci) % 256);
  endfunction

  // called just after a negedge: compare what the last posedge produced, then drive next
  task automatic drive(int v, int op, int a, int b, int clr, int hlt, int wto);
    compare_all();
    alu_valid_i = v[0]; alu_op_i = 3'(op); opa_i = 8'(a); opb_i = 8'(b);
    res_i = (op >= 1 && op <= 4) ? arith_res(op, a, b, m_c) : 8'($urandom_range(0, 3) == 0 ? 0 : $urandom);
    wdt_clr_i = clr[0]; halt_i = hlt[0]; wdt_to_i = wto[0];
    model_step();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", status_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", status_o, 0);
    drive(1, 1, 8'h7F, 8'h01, 0, 0, 0);
    drive(1, 3, 8'h80, 8'h01, 0, 0, 0);
    drive(1, 1, 8'hFF, 8'h01, 0, 0, 0);   // carry, zero, nibble
    drive(1, 2, 8'h10, 8'h20, 0, 0, 0);   // ADC with carry in
    drive(1, 3, 8'h05, 8'h05, 0, 0, 0);   // SUB equal: no borrow, zero
    drive(1, 4, 8'h00, 8'h00, 0, 0, 0);   // SBC with carry 1
    drive(1, 3, 8'h00, 8'h01, 0, 0, 0);   // borrow
    drive(1, 4, 8'h00, 8'h00, 0, 0, 0);   // SBC with carry 0
    drive(1, 5, 8'h00, 8'h00, 0, 0, 0);   // logic keeps C/AC/OV (R6)
    drive(1, 6, 8'h80, 8'h00, 0, 0, 0);   // ROL loads 1 (R6)
    drive(1, 7, 8'hFE, 8'h00, 0, 0, 0);   // ROR loads 0 (R6)
    drive(0, 1, 8'hFF, 8'hFF, 0, 0, 0);   // invalid op ignored (R6)
    drive(1, 0, 8'hFF, 8'hFF, 0, 0, 0);   // code 0 ignored (R6)
    drive(0, 0, 0, 0, 0, 1, 0);           // halt sets sleep (R7)
    drive(0, 0, 0, 0, 0, 0, 1);           // expiry set (R8)
    drive(0, 0, 0, 0, 1, 1, 1);           // clear wins sleep, expiry wins (R7 R8)
    drive(0, 0, 0, 0, 0, 1, 0);           // halt clears expiry (R8)
    drive(0, 0, 0, 0, 1, 0, 0);           // clear
    drive(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom_range(0, 4) != 0) ? 1 : 0, $urandom_range(0, 7), $urandom_range(0, 255),
            $urandom_range(0, 255), ($urandom_range(0, 9) == 0) ? 1 : 0,
            ($urandom_range(0, 9) == 0) ? 1 : 0, ($urandom_range(0, 9) == 0) ? 1 : 0);
    end
    drive(0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    m_c = 0; m_ac = 0; m_z = 0; m_ov = 0; m_pd = 0; m_to = 0;
    @(negedge clk);
    chk("R1 mid-run reset", status_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule